// File: doc/BRIEF.md
# Synchronisation Peak Search with Start-up Hold-off

This block sits after a time-domain correlator that compares the incoming sample stream with a known synchronising sequence. On every valid sample it receives two values: the correlation magnitude and the signal energy over the correlator span. The energy is multiplied by a fractional scale factor to form a detection threshold. The block finds the sample at which the synchronising sequence is best aligned, and a downstream timing-adjust stage uses that position.

After reset the block ignores a fixed number of valid samples, by default 23040 (12 ms at 1.92 Msps). This gives the front end time to settle. After that it splits the valid-sample stream into back-to-back windows, by default 5760 samples (3 ms). In each window it keeps the largest correlation value that beats the threshold, along with that sample's position. When a window closes it presents the position, a detection flag and a single-cycle strobe. It then forgets the peak and starts the next window.

Top module: `sync_peak_search`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `win_done`, `found`, `offset_out` and `search_active` are all 0.
- R2: The first HOLDOFF_LEN (default 23040) valid samples after reset are never candidates and produce no report. `search_active` becomes 1 on the cycle after the clock edge that takes the HOLDOFF_LEN-th valid sample, and stays 1 until reset.
- R3: A cycle with `valid_in` low advances no counter and changes no held peak, whatever `corr_in`, `energy_in` and `thr_scale_in` carry.
- R4: A sample is a candidate only when `corr_in * 2^SCALE_FRAC` is strictly greater than `energy_in * thr_scale_in`, with all three unsigned and SCALE_FRAC default 4. A threshold exactly equal to the correlation is not a candidate.
- R5: Within a window, a candidate replaces the held peak only if its `corr_in` is strictly greater than the held value. On equal values the earlier position is kept.
- R6: Once searching, every WIN_LEN (default 5760) valid samples form one window. `win_done` is high for exactly one cycle, on the cycle after the clock edge that takes the window's last valid sample.
- R7: With the report, `found` is 1 and `offset_out` is the zero-based count of valid samples from the window start to the peak sample (0 to WIN_LEN-1) if the window had a candidate. Otherwise both are 0. Both hold until the next report.
- R8: After each report the held peak is cleared, so a window whose best candidate is lower than the previous window's peak still reports it.
- R9: Asserting `rst` in the middle of a search restarts the full hold-off before any further report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Qualifies the sample inputs this cycle |
| corr_in | input | METRIC_W (24) | Unsigned correlation magnitude |
| energy_in | input | ENERGY_W (24) | Unsigned energy over the correlator span |
| thr_scale_in | input | SCALE_W (8) | Unsigned threshold scale, SCALE_FRAC fractional bits |
| search_active | output | 1 | Hold-off is over and windows are being searched |
| win_done | output | 1 | One-cycle strobe at each window close |
| found | output | 1 | The last closed window contained a candidate |
| offset_out | output | $clog2(WIN_LEN) (13) | Peak position within the last closed window |

## Verification
Embedded assertions check the following on every cycle:
- the report strobe never lasts two cycles;
- an empty report carries a zero offset, and every offset stays inside the window;
- idle cycles leave the window position and peak frozen;
- the held peak never falls inside a window;
- a report always comes with search enabled and a freshly cleared tracker.

Only the bench's scenarios show the following:
- the exact hold-off length;
- the strict threshold comparison, including the fractional-scale equality case;
- tie handling and the last-sample boundary;
- a window that reports a lower peak than its predecessor;
- the restart after a mid-window reset.

These scenarios are compared against a behavioural model on every clock.

// File: rtl/spk_pkg.sv
package spk_pkg;
   function automatic int spk_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int spk_cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/spk_holdoff.sv
module spk_holdoff #(
   parameter int HOLDOFF_LEN = 23040
) (
   input  logic clk,
   input  logic rst,
   input  logic valid_in,
   output logic armed
);
   localparam int CW = spk_pkg::spk_cnt_w(HOLDOFF_LEN);
   localparam logic [CW-1:0] LAST = CW'(HOLDOFF_LEN - 1);

   logic [CW-1:0] cnt_q;
   logic          armed_q;

   if (HOLDOFF_LEN < 1) begin : g_bad_len
      $error("spk_holdoff: HOLDOFF_LEN must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (valid_in && !armed_q) begin
         if (cnt_q == LAST) begin
            armed_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign armed = armed_q;

   // R2
   armed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      armed |=> armed);

   // R3
   idle_count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(cnt_q));
endmodule

// File: rtl/spk_thresh_cmp.sv
module spk_thresh_cmp #(
   parameter int METRIC_W   = 24,
   parameter int ENERGY_W   = 24,
   parameter int SCALE_W    = 8,
   parameter int SCALE_FRAC = 4
) (
   input  logic [METRIC_W-1:0] corr_in,
   input  logic [ENERGY_W-1:0] energy_in,
   input  logic [SCALE_W-1:0]  thr_scale_in,
   output logic                above
);
   localparam int PROD_W = ENERGY_W + SCALE_W;
   localparam int LHS_W  = METRIC_W + SCALE_FRAC;
   localparam int CMP_W  = spk_pkg::spk_max(PROD_W, LHS_W);

   logic [PROD_W-1:0] prod;
   logic [CMP_W-1:0]  lhs;
   logic [CMP_W-1:0]  rhs;

   if (SCALE_FRAC < 0 || SCALE_FRAC > SCALE_W) begin : g_bad_frac
      $error("spk_thresh_cmp: SCALE_FRAC out of range");
   end

   assign prod = PROD_W'(energy_in) * PROD_W'(thr_scale_in);
   assign rhs  = CMP_W'(prod);

   if (SCALE_FRAC == 0) begin : g_int_scale
      assign lhs = CMP_W'(corr_in);
   end else begin : g_frac_scale
      assign lhs = CMP_W'({corr_in, {SCALE_FRAC{1'b0}}});
   end

   assign above = (lhs > rhs);
endmodule

// File: rtl/spk_window_tracker.sv
module spk_window_tracker #(
   parameter int METRIC_W = 24,
   parameter int WIN_LEN  = 5760,
   localparam int OFS_W   = spk_pkg::spk_cnt_w(WIN_LEN)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                valid_in,
   input  logic                armed,
   input  logic                above,
   input  logic [METRIC_W-1:0] corr_in,
   output logic                win_done,
   output logic                found,
   output logic [OFS_W-1:0]    offset_out
);
   localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(WIN_LEN - 1);

   logic [OFS_W-1:0]    idx_q;
   logic [METRIC_W-1:0] peak_q;
   logic [OFS_W-1:0]    best_q;
   logic                have_q;
   logic                done_q;
   logic                found_q;
   logic [OFS_W-1:0]    ofs_q;

   logic                take;
   logic                at_last;
   logic                beats;
   logic                nxt_have;
   logic [METRIC_W-1:0] nxt_peak;
   logic [OFS_W-1:0]    nxt_best;

   if (WIN_LEN < 2) begin : g_bad_win
      $error("spk_window_tracker: WIN_LEN must be at least 2");
   end

   if (WIN_LEN == (1 << OFS_W)) begin : g_pow2_win
      assign at_last = &idx_q;
   end else begin : g_any_win
      assign at_last = (idx_q == LAST_IDX);
   end

   assign take     = valid_in && armed;
   assign beats    = take && above && (!have_q || (corr_in > peak_q));
   assign nxt_have = have_q || beats;
   assign nxt_peak = beats ? corr_in : peak_q;
   assign nxt_best = beats ? idx_q : best_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q   <= '0;
         peak_q  <= '0;
         best_q  <= '0;
         have_q  <= 1'b0;
         done_q  <= 1'b0;
         found_q <= 1'b0;
         ofs_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            if (at_last) begin
               done_q  <= 1'b1;
               found_q <= nxt_have;
               ofs_q   <= nxt_have ? nxt_best : '0;
               idx_q   <= '0;
               peak_q  <= '0;
               best_q  <= '0;
               have_q  <= 1'b0;
            end else begin
               idx_q  <= idx_q + OFS_W'(1);
               peak_q <= nxt_peak;
               best_q <= nxt_best;
               have_q <= nxt_have;
            end
         end
      end
   end

   assign win_done   = done_q;
   assign found      = found_q;
   assign offset_out = ofs_q;

   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      win_done |=> !win_done);

   // R7
   empty_zero_ofs_chk: assert property (@(posedge clk) disable iff (rst)
      !found |-> (offset_out == '0));

   // R7
   ofs_in_window_chk: assert property (@(posedge clk) disable iff (rst)
      offset_out <= LAST_IDX);

   // R3
   idle_state_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> ($stable(idx_q) && $stable(peak_q) && $stable(have_q)));

   // R5
   peak_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
      (take && !at_last) |=> (peak_q >= $past(peak_q)));

   // R8
   cleared_on_report_chk: assert property (@(posedge clk) disable iff (rst)
      win_done |-> (!have_q && (idx_q == '0) && (peak_q == '0)));
endmodule

// File: rtl/sync_peak_search.sv
module sync_peak_search #(
   parameter int METRIC_W    = 24,
   parameter int ENERGY_W    = 24,
   parameter int SCALE_W     = 8,
   parameter int SCALE_FRAC  = 4,
   parameter int HOLDOFF_LEN = 23040,
   parameter int WIN_LEN     = 5760,
   localparam int OFS_W      = spk_pkg::spk_cnt_w(WIN_LEN)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                valid_in,
   input  logic [METRIC_W-1:0] corr_in,
   input  logic [ENERGY_W-1:0] energy_in,
   input  logic [SCALE_W-1:0]  thr_scale_in,
   output logic                search_active,
   output logic                win_done,
   output logic                found,
   output logic [OFS_W-1:0]    offset_out
);
   logic armed;
   logic above;

   if (METRIC_W < 1 || ENERGY_W < 1 || SCALE_W < 1) begin : g_bad_width
      $error("sync_peak_search: widths must be positive");
   end

   spk_holdoff #(
      .HOLDOFF_LEN(HOLDOFF_LEN)
   ) holdoff_i (
      .clk     (clk),
      .rst     (rst),
      .valid_in(valid_in),
      .armed   (armed)
   );

   spk_thresh_cmp #(
      .METRIC_W  (METRIC_W),
      .ENERGY_W  (ENERGY_W),
      .SCALE_W   (SCALE_W),
      .SCALE_FRAC(SCALE_FRAC)
   ) thresh_i (
      .corr_in     (corr_in),
      .energy_in   (energy_in),
      .thr_scale_in(thr_scale_in),
      .above       (above)
   );

   spk_window_tracker #(
      .METRIC_W(METRIC_W),
      .WIN_LEN (WIN_LEN)
   ) tracker_i (
      .clk       (clk),
      .rst       (rst),
      .valid_in  (valid_in),
      .armed     (armed),
      .above     (above),
      .corr_in   (corr_in),
      .win_done  (win_done),
      .found     (found),
      .offset_out(offset_out)
   );

   assign search_active = armed;

   // R2
   report_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
      win_done |-> search_active);
endmodule

// File: tb/sync_peak_search_tb_top.sv
module sync_peak_search_tb_top;
   localparam int HOLD = 23040;
   localparam int WIN  = 5760;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_in = 1'b0;
   logic [23:0] corr_in = '0;
   logic [23:0] energy_in = '0;
   logic [7:0]  thr_scale_in = '0;
   logic        search_active;
   logic        win_done;
   logic        found;
   logic [12:0] offset_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sync_peak_search dut_i (
      .clk(clk), .rst(rst), .valid_in(valid_in), .corr_in(corr_in),
      .energy_in(energy_in), .thr_scale_in(thr_scale_in),
      .search_active(search_active), .win_done(win_done),
      .found(found), .offset_out(offset_out)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int     m_hold;
   bit     m_armed;
   int     m_idx;
   longint m_peak;
   bit     m_have;
   int     m_best;
   bit     m_done, m_found;
   int     m_ofs;

   always @(posedge clk) begin
      if (rst) begin
         m_hold = 0; m_armed = 0; m_idx = 0; m_peak = 0; m_have = 0;
         m_best = 0; m_done = 0; m_found = 0; m_ofs = 0;
      end else begin
         m_done = 0;
         if (valid_in) begin
            if (!m_armed) begin
               m_hold++;
               if (m_hold == HOLD) m_armed = 1;
            end else begin
               if ((longint'(corr_in) * 16 > longint'(energy_in) * longint'(thr_scale_in))
                   && (!m_have || longint'(corr_in) > m_peak)) begin
                  m_have = 1; m_peak = corr_in; m_best = m_idx;
               end
               if (m_idx == WIN - 1) begin
                  m_done = 1; m_found = m_have; m_ofs = m_have ? m_best : 0;
                  m_idx = 0; m_have = 0; m_peak = 0; m_best = 0;
               end else begin
                  m_idx++;
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (!finished) begin
         chk("R2 search_active vs model", search_active, m_armed);
         chk("R6 win_done vs model", win_done, m_done);
         chk("R7 found vs model", found, m_found);
         chk("R7 offset_out vs model", offset_out, m_ofs);
      end
   end

   task automatic send(input bit v, input int c, input int e, input int s);
      valid_in = v; corr_in = 24'(c); energy_in = 24'(e); thr_scale_in = 8'(s);
      @(negedge clk);
   endtask

   // one window; spikes given as position, corr, energy, scale
   task automatic send_window(input int n, input int si[4], input int sc[4],
                              input int se[4], input int ss[4]);
      for (int i = 0; i < WIN; i++) begin
         int c = 0, e = 100, s = 16;
         for (int k = 0; k < n; k++)
            if (si[k] == i) begin c = sc[k]; e = se[k]; s = ss[k]; end
         send(1'b1, c, e, s);
         if (i % 1500 == 700) send(1'b0, 70000, 1, 1);  // R3 junk on idle cycle
      end
   endtask

   task automatic run_holdoff(input string tag);
      for (int i = 0; i < HOLD; i++) begin
         send(1'b1, (i == 5 || i == HOLD - 1) ? 9000 : 0, 100, 16);
         if (i % 4000 == 3) send(1'b0, 70000, 1, 1);
         if (i == HOLD - 2) chk({tag, " active before end of hold-off"}, search_active, 0);
      end
      chk({tag, " active after hold-off"}, search_active, 1);
      chk({tag, " no report during hold-off"}, found, 0);
   endtask

   initial begin
      int si[4], sc[4], se[4], ss[4];
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 win_done in reset", win_done, 0);
      chk("R1 found in reset", found, 0);
      chk("R1 offset in reset", offset_out, 0);
      chk("R1 active in reset", search_active, 0);
      rst = 1'b0;
      run_holdoff("R2");

      // window 1: tie at 100 and 200 -> earliest kept (R5)
      si = '{100, 200, 300, 0}; sc = '{500, 500, 400, 0};
      se = '{100, 100, 100, 0}; ss = '{16, 16, 16, 0};
      send_window(3, si, sc, se, ss);
      chk("R6 strobe at window close", win_done, 1);
      chk("R5 tie keeps earliest", offset_out, 100);
      chk("R7 found window1", found, 1);
      send(1'b0, 0, 100, 16);
      chk("R6 strobe lasts one cycle", win_done, 0);
      chk("R7 offset held after strobe", offset_out, 100);

      // window 2: equality rejected, high thr rejected, lower peak reported
      si = '{10, 50, 4000, 0}; sc = '{300, 100, 101, 0};
      se = '{400, 100, 100, 0}; ss = '{16, 16, 16, 0};
      send_window(3, si, sc, se, ss);
      chk("R4 equal threshold rejected, R8 lower peak reported", offset_out, 4000);
      chk("R3 idle junk ignored", found, 1);

      // window 3: only an exact fractional-scale tie -> nothing
      si = '{20, 0, 0, 0}; sc = '{96, 0, 0, 0};
      se = '{64, 0, 0, 0}; ss = '{24, 0, 0, 0};
      send_window(1, si, sc, se, ss);
      chk("R4 fractional equality rejected: found", found, 0);
      chk("R7 empty window offset zero", offset_out, 0);

      // window 4: fractional pass at 0, larger at last position
      si = '{0, 5759, 0, 0}; sc = '{97, 1000, 0, 0};
      se = '{64, 100, 0, 0}; ss = '{24, 16, 0, 0};
      send_window(2, si, sc, se, ss);
      chk("R7 peak at last position", offset_out, 5759);
      chk("R7 found window4", found, 1);

      // mid-window reset (R9)
      for (int i = 0; i < 3000; i++) send(1'b1, (i == 10) ? 800 : 0, 100, 16);
      rst = 1'b1;
      send(1'b1, 0, 100, 16);
      send(1'b1, 0, 100, 16);
      chk("R9 active cleared by reset", search_active, 0);
      chk("R1 found cleared by reset", found, 0);
      rst = 1'b0;
      send(1'b0, 0, 100, 16);
      chk("R1 offset zero after reset", offset_out, 0);
      run_holdoff("R9");
      si = '{7, 0, 0, 0}; sc = '{250, 0, 0, 0};
      se = '{100, 0, 0, 0}; ss = '{16, 0, 0, 0};
      send_window(1, si, sc, se, ss);
      chk("R9 report after restart", offset_out, 7);
      chk("R9 strobe after restart", win_done, 1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule